// File: doc/BRIEF.md
# CAN Nominal Bit Timing Generator

This block turns the system clock into the time base of a CAN controller. A prescaler cuts the clock into time quanta (tq). The block then lays out each nominal bit as three parts: a one-quantum sync segment, a first phase segment (propagation plus phase 1) and a second phase segment. At the end of the first phase segment it takes the bus value, either as one sample or as a majority of three. It reports the result on `rx_bit`, marks the sample point with `sample_stb`, and marks the start of every bit with `tx_stb` so a transmitter knows when to drive its next bit.

A falling (recessive-to-dominant) edge on the received line shifts the bit boundaries. If the edge lands in the first phase segment, that segment is lengthened. If it lands in the second phase segment, that segment is shortened. The jump width limits either change, and at most one such change is allowed between two sample points. Edges caused by the node's own dominant output are ignored.

Timing fields can be loaded only while the block is in initialization mode, which it enters at reset. The timing runs only while `run` is held high. Frame decoding and error counting belong to the logic around this block.

Top module: `can_bit_timer`

## Requirements
- R1: After reset the block is in initialization mode: `init_mode`=1, `rx_bit`=1 (recessive), `sample_stb`=0 and `tx_stb`=0. No strobe appears while `init_mode` is 1.
- R2: A configuration write (`cfg_we`=1) is taken only in a clock where `init_mode` is 1. A write made while `init_mode` is 0 leaves the bit timing unchanged.
- R3: One tq lasts `cfg_brp`+1 clocks. Without resynchronization a bit lasts 1+`cfg_tseg1`+`cfg_tseg2` tq. A value of 0 written to `cfg_tseg1`, `cfg_tseg2` or `cfg_sjw` is stored as 1. The shortest bit is therefore 3 clocks, which allows more than 1 Mbit/s from any clock above 3 MHz.
- R4: `tx_stb` is a one-clock pulse in the clock after the first clock of every sync segment. This includes the first bit after leaving initialization.
- R5: `sample_stb` is a one-clock pulse in the clock after the last clock of the first phase segment. `rx_bit` takes its new value in that same clock and holds it until the next pulse.
- R6: With `cfg_triple`=0 the sampled bit is `rx_in` at the last clock of the sample-point tq. With `cfg_triple`=1 it is the majority of `rx_in` at the last clock of the sample-point tq and at the last clocks of the two tq before it.
- R7: A valid edge is `rx_in`=0 in a clock where `rx_in` was 1 in the previous clock and `tx_dom`=0. A valid edge in quantum k (counting from 0) of the first phase segment lengthens that segment by min(k+1, SJW) tq.
- R8: A valid edge in quantum k (counting from 0) of the second phase segment, whose current length is L, shortens that segment by min(L-k-1, SJW) tq. The quantum in progress always completes.
- R9: Edges in the sync segment and edges with `tx_dom`=1 cause no adjustment. After one adjustment, further edges are ignored until the next sample point.
- R10: `init_mode` follows `~run` one clock later. While `init_mode` is 1 the timing is held. When it returns to 0 the timing restarts with a sync segment. The three-sample history restarts as recessive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | 1 requests normal mode, 0 requests initialization mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_brp | input | 6 | Prescaler: tq = value+1 clocks |
| cfg_tseg1 | input | 4 | First phase segment length in tq (0 read as 1) |
| cfg_tseg2 | input | 3 | Second phase segment length in tq (0 read as 1) |
| cfg_sjw | input | 2 | Jump width in tq (0 read as 1) |
| cfg_triple | input | 1 | 1 selects three-sample majority |
| rx_in | input | 1 | Received bus level, already synchronized (1 = recessive) |
| tx_dom | input | 1 | 1 while this node drives dominant |
| init_mode | output | 1 | 1 while in initialization mode |
| rx_bit | output | 1 | Last sampled bit value |
| sample_stb | output | 1 | Sample point pulse |
| tx_stb | output | 1 | Start-of-bit pulse |

## Verification
The hardest case to reach is an edge that arrives while a resynchronization is already spent. A second edge in the same bit, or an edge in the next bit's first phase segment before its sample point, must be ignored. This takes several falling edges within one bit, at positions that drift relative to the quanta. The stimulus drives `rx_in` from a pseudo-random sequence that changes every two clocks, with short segments and a one-clock quantum. This places edges in every segment, including repeats inside one resynchronization window. A cycle-by-cycle behavioural model tracks each quantum position, and any gap in the lockout shows up as a strobe in the wrong clock.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_PH1  = 2'd1,
    SEG_PH2  = 2'd2
  } seg_e;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/can_bt_cfg.sv
module can_bt_cfg #(
  parameter int BRP_W  = 6,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              we,
  input  logic [BRP_W-1:0]  brp_in,
  input  logic [SEG1_W-1:0] t1_in,
  input  logic [SEG2_W-1:0] t2_in,
  input  logic [SJW_W-1:0]  sjw_in,
  input  logic              tri_in,
  output logic              init_mode,
  output logic [BRP_W-1:0]  brp_q,
  output logic [SEG1_W-1:0] t1_q,
  output logic [SEG2_W-1:0] t2_q,
  output logic [SJW_W-1:0]  sjw_q,
  output logic              tri_q
);
  localparam logic [SEG1_W-1:0] T1_MIN  = SEG1_W'(1);
  localparam logic [SEG2_W-1:0] T2_MIN  = SEG2_W'(1);
  localparam logic [SJW_W-1:0]  SJW_MIN = SJW_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      init_mode <= 1'b1;
      brp_q     <= '0;
      t1_q      <= T1_MIN;
      t2_q      <= T2_MIN;
      sjw_q     <= SJW_MIN;
      tri_q     <= 1'b0;
    end else begin
      init_mode <= ~run;
      if (we && init_mode) begin
        brp_q <= brp_in;
        t1_q  <= (t1_in == '0) ? T1_MIN : t1_in;
        t2_q  <= (t2_in == '0) ? T2_MIN : t2_in;
        sjw_q <= (sjw_in == '0) ? SJW_MIN : sjw_in;
        tri_q <= tri_in;
      end
    end
  end

  // R2
  cfg_lock_chk: assert property (@(posedge clk) disable iff (rst)
    !init_mode |=> $stable({brp_q, t1_q, t2_q, sjw_q, tri_q}));

  // R3
  cfg_min_chk: assert property (@(posedge clk) disable iff (rst)
    (t1_q != '0) && (t2_q != '0) && (sjw_q != '0));
endmodule

// File: rtl/can_bt_prescale.sv
module can_bt_prescale #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [BRP_W-1:0] brp,
  output logic             tq_end,
  output logic             tq_start
);
  logic [BRP_W-1:0] pcnt;

  assign tq_end   = run && (pcnt == brp);
  assign tq_start = run && (pcnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !run) pcnt <= '0;
    else if (pcnt == brp) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end

  // R3
  psc_range_chk: assert property (@(posedge clk) disable iff (rst)
    pcnt <= brp);

  // R3
  psc_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (run && tq_end) |=> (pcnt == '0));
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              tq_end,
  input  logic              tq_start,
  input  logic [SEG1_W-1:0] tseg1,
  input  logic [SEG2_W-1:0] tseg2,
  input  logic [SJW_W-1:0]  sjw,
  input  logic              triple,
  input  logic              rx_in,
  input  logic              tx_dom,
  output logic              rx_bit,
  output logic              sample_stb,
  output logic              tx_stb
);
  localparam int SEG_MAX = (SEG1_W > SEG2_W) ? SEG1_W : SEG2_W;
  localparam int CNT_W   = SEG_MAX + 1;

  seg_e             seg;
  logic [CNT_W-1:0] qcnt, ext, ts2_len;
  logic             resynced, prev_rx;
  logic [1:0]       hist;

  logic [CNT_W-1:0] sjw_x, e1, e2, adj1, adj2, ext_nxt, ts2_nxt, ph1_len;
  logic             edge_ok, rs_ph1, rs_ph2, ph1_done, ph2_done;

  assign sjw_x   = CNT_W'(sjw);
  assign edge_ok = run && prev_rx && !rx_in && !tx_dom && !resynced;
  assign rs_ph1  = edge_ok && (seg == SEG_PH1);
  assign rs_ph2  = edge_ok && (seg == SEG_PH2);

  always_comb begin
    e1      = qcnt + 1'b1;
    e2      = ts2_len - qcnt - 1'b1;
    adj1    = (e1 < sjw_x) ? e1 : sjw_x;
    adj2    = (e2 < sjw_x) ? e2 : sjw_x;
    ext_nxt = rs_ph1 ? adj1 : ext;
    ts2_nxt = rs_ph2 ? (ts2_len - adj2) : ts2_len;
    ph1_len = CNT_W'(tseg1) + ext_nxt;
  end

  assign ph1_done = tq_end && (seg == SEG_PH1) && (qcnt == ph1_len - 1'b1);
  assign ph2_done = tq_end && (seg == SEG_PH2) && (qcnt == ts2_nxt - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) prev_rx <= 1'b1;
    else prev_rx <= rx_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg        <= SEG_SYNC;
      qcnt       <= '0;
      ext        <= '0;
      ts2_len    <= '0;
      resynced   <= 1'b0;
      hist       <= 2'b11;
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else if (!run) begin
      seg        <= SEG_SYNC;
      qcnt       <= '0;
      ext        <= '0;
      resynced   <= 1'b0;
      hist       <= 2'b11;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else begin
      sample_stb <= ph1_done;
      tx_stb     <= (seg == SEG_SYNC) && tq_start;
      ext        <= ext_nxt;
      ts2_len    <= ts2_nxt;
      if (tq_end) hist <= {hist[0], rx_in};
      if (ph1_done) begin
        rx_bit   <= triple ? vote3(hist[1], hist[0], rx_in) : rx_in;
        resynced <= 1'b0;
      end else if (edge_ok && (seg != SEG_SYNC)) begin
        resynced <= 1'b1;
      end
      if (tq_end) begin
        unique case (seg)
          SEG_SYNC: begin
            seg  <= SEG_PH1;
            qcnt <= '0;
          end
          SEG_PH1: begin
            if (ph1_done) begin
              seg     <= SEG_PH2;
              qcnt    <= '0;
              ext     <= '0;
              ts2_len <= CNT_W'(tseg2);
            end else qcnt <= qcnt + 1'b1;
          end
          default: begin
            if (ph2_done) begin
              seg  <= SEG_SYNC;
              qcnt <= '0;
            end else qcnt <= qcnt + 1'b1;
          end
        endcase
      end
    end
  end

  // R5
  sample_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);

  // R5
  rx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !sample_stb |-> $stable(rx_bit));

  // R4
  tx_apart_chk: assert property (@(posedge clk) disable iff (rst)
    tx_stb |-> !sample_stb);

  // R7
  ext_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ext <= sjw_x);

  // R8
  ph2_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (seg == SEG_PH2) |-> (qcnt < ts2_len));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!sample_stb && !tx_stb));
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer #(
  parameter int BRP_W  = 6,
  parameter int SEG1_W = 4,
  parameter int SEG2_W = 3,
  parameter int SJW_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              cfg_we,
  input  logic [BRP_W-1:0]  cfg_brp,
  input  logic [SEG1_W-1:0] cfg_tseg1,
  input  logic [SEG2_W-1:0] cfg_tseg2,
  input  logic [SJW_W-1:0]  cfg_sjw,
  input  logic              cfg_triple,
  input  logic              rx_in,
  input  logic              tx_dom,
  output logic              init_mode,
  output logic              rx_bit,
  output logic              sample_stb,
  output logic              tx_stb
);
  logic [BRP_W-1:0]  brp_q;
  logic [SEG1_W-1:0] t1_q;
  logic [SEG2_W-1:0] t2_q;
  logic [SJW_W-1:0]  sjw_q;
  logic              tri_q, tq_end, tq_start;

  can_bt_cfg #(.BRP_W(BRP_W), .SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_cfg (
    .clk(clk), .rst(rst), .run(run), .we(cfg_we),
    .brp_in(cfg_brp), .t1_in(cfg_tseg1), .t2_in(cfg_tseg2), .sjw_in(cfg_sjw),
    .tri_in(cfg_triple), .init_mode(init_mode),
    .brp_q(brp_q), .t1_q(t1_q), .t2_q(t2_q), .sjw_q(sjw_q), .tri_q(tri_q)
  );

  can_bt_prescale #(.BRP_W(BRP_W)) u_psc (
    .clk(clk), .rst(rst), .run(!init_mode), .brp(brp_q),
    .tq_end(tq_end), .tq_start(tq_start)
  );

  can_bt_seq #(.SEG1_W(SEG1_W), .SEG2_W(SEG2_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .run(!init_mode), .tq_end(tq_end), .tq_start(tq_start),
    .tseg1(t1_q), .tseg2(t2_q), .sjw(sjw_q), .triple(tri_q),
    .rx_in(rx_in), .tx_dom(tx_dom),
    .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb)
  );
endmodule

// File: tb/can_bit_timer_test.sv
module can_bit_timer_test;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       run = 1'b0;
  logic       cfg_we = 1'b0;
  logic [5:0] cfg_brp = '0;
  logic [3:0] cfg_tseg1 = '0;
  logic [2:0] cfg_tseg2 = '0;
  logic [1:0] cfg_sjw = '0;
  logic       cfg_triple = 1'b0;
  logic       rx_in = 1'b1;
  logic       tx_dom = 1'b0;
  logic       init_mode, rx_bit, sample_stb, tx_stb;

  int total = 0;
  int bad = 0;
  string tag = "R1";
  int unsigned seed = 32'h1234_5678;

  can_bit_timer uut (
    .clk(clk), .rst(rst), .run(run), .cfg_we(cfg_we), .cfg_brp(cfg_brp),
    .cfg_tseg1(cfg_tseg1), .cfg_tseg2(cfg_tseg2), .cfg_sjw(cfg_sjw),
    .cfg_triple(cfg_triple), .rx_in(rx_in), .tx_dom(tx_dom),
    .init_mode(init_mode), .rx_bit(rx_bit), .sample_stb(sample_stb), .tx_stb(tx_stb)
  );

  always #(CLK_P/2) clk = ~clk;

  // behavioural reference: position of the current quantum inside the bit
  int m_init, m_brp, m_t1, m_t2, m_sjw, m_tri;
  int pc, tq, len1, len2, rs, prv, h1, h0;
  int e_bit, e_s, e_tx, e_init;

  always @(posedge clk) begin
    if (rst) begin
      m_init = 1; m_brp = 0; m_t1 = 1; m_t2 = 1; m_sjw = 1; m_tri = 0;
      pc = 0; tq = 0; len1 = 1; len2 = 1; rs = 0; prv = 1; h1 = 1; h0 = 1;
      e_bit = 1; e_s = 0; e_tx = 0; e_init = 1;
    end else begin
      int running;
      running = (m_init == 0);
      if (cfg_we && m_init == 1) begin
        m_brp = cfg_brp;
        m_t1 = (cfg_tseg1 == 0) ? 1 : int'(cfg_tseg1);
        m_t2 = (cfg_tseg2 == 0) ? 1 : int'(cfg_tseg2);
        m_sjw = (cfg_sjw == 0) ? 1 : int'(cfg_sjw);
        m_tri = cfg_triple;
      end
      if (!running) begin
        pc = 0; tq = 0; len1 = m_t1; rs = 0; h1 = 1; h0 = 1;
        e_s = 0; e_tx = 0;
      end else begin
        int smp, k, d;
        smp = 0;
        e_tx = (tq == 0 && pc == 0);
        if (prv == 1 && rx_in == 1'b0 && tx_dom == 1'b0 && rs == 0 && tq > 0) begin
          if (tq <= len1) begin
            k = tq - 1;
            d = (k + 1 < m_sjw) ? k + 1 : m_sjw;
            len1 += d;
          end else begin
            k = tq - 1 - len1;
            d = (len2 - k - 1 < m_sjw) ? len2 - k - 1 : m_sjw;
            len2 -= d;
          end
          rs = 1;
        end
        if (pc == m_brp) begin
          pc = 0;
          if (tq == len1) begin
            smp = 1; rs = 0; len2 = m_t2;
            e_bit = m_tri ? ((h1 + h0 + int'(rx_in)) >= 2) : int'(rx_in);
          end
          h1 = h0; h0 = rx_in;
          if (tq == len1 + len2 && tq > len1) begin
            tq = 0; len1 = m_t1;
          end else tq++;
        end else pc++;
        e_s = smp;
      end
      prv = rx_in;
      m_init = run ? 0 : 1;
      e_init = m_init;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  bit cmp_on = 1'b0;
  always @(negedge clk) begin
    if (cmp_on && !rst) begin
      chk(tag, "init_mode", init_mode, e_init);
      chk(tag, "sample_stb", sample_stb, e_s);
      chk(tag, "tx_stb", tx_stb, e_tx);
      chk(tag, "rx_bit", rx_bit, e_bit);
    end
  end

  task automatic clocks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setcfg(input int b, input int t1, input int t2, input int j, input int tr);
    @(negedge clk);
    cfg_we = 1'b1; cfg_brp = 6'(b); cfg_tseg1 = 4'(t1); cfg_tseg2 = 3'(t2);
    cfg_sjw = 2'(j); cfg_triple = tr[0];
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic noisy(input int n, input int hold, input int txd);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i % hold == 0) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        rx_in = seed[16];
        tx_dom = (txd == 2) ? seed[20] : txd[0];
      end
    end
  endtask

  // sample-to-sample distance measured at the ports
  task automatic gap(input string req, input int exp);
    int c;
    c = 0;
    while (sample_stb !== 1'b1 && c < 500) begin @(negedge clk); c++; end
    @(negedge clk);
    c = 1;
    while (sample_stb !== 1'b1 && c < 500) begin @(negedge clk); c++; end
    chk(req, "sample gap", c, exp);
  endtask

  bit done = 1'b0;
  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    clocks(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "init_mode", init_mode, 1);
    chk("R1", "rx_bit", rx_bit, 1);
    chk("R1", "sample_stb", sample_stb, 0);
    chk("R1", "tx_stb", tx_stb, 0);
    cmp_on = 1'b1;
    tag = "R1";
    noisy(20, 1, 0);
    rx_in = 1'b1; tx_dom = 1'b0;

    // R3 basic timing: 2 clk/tq, bit of 6 tq
    tag = "R3";
    setcfg(1, 3, 2, 1, 0);
    run = 1'b1;
    clocks(2);
    gap("R3", 12);
    clocks(30);

    // R2 writes in normal mode are dropped
    tag = "R2";
    setcfg(0, 9, 5, 3, 1);
    gap("R2", 12);
    clocks(20);

    // R3 zero fields clamp to 1: 3-clock bit
    tag = "R3";
    run = 1'b0;
    clocks(3);
    setcfg(0, 0, 0, 0, 0);
    run = 1'b1;
    clocks(2);
    gap("R3", 3);

    // R4 start strobes and R5 sampling of a changing bus
    tag = "R4";
    run = 1'b0; clocks(3);
    setcfg(2, 4, 3, 2, 0);
    run = 1'b1;
    clocks(60);
    tag = "R5";
    noisy(300, 5, 1);

    // R6 triple sampling with short glitches
    tag = "R6";
    run = 1'b0; clocks(3);
    setcfg(1, 5, 2, 2, 1);
    run = 1'b1;
    noisy(400, 2, 1);
    setcfg(1, 5, 2, 2, 0);

    // R7 edges in the first phase segment, R8 in the second
    tag = "R7";
    run = 1'b0; clocks(3);
    setcfg(0, 6, 4, 3, 0);
    run = 1'b1;
    noisy(500, 3, 0);
    tag = "R8";
    run = 1'b0; clocks(3);
    setcfg(1, 3, 7, 2, 0);
    run = 1'b1;
    noisy(500, 4, 0);

    // R9 dense edges, own-transmit masking, lockout window
    tag = "R9";
    run = 1'b0; clocks(3);
    setcfg(0, 5, 3, 3, 1);
    run = 1'b1;
    noisy(800, 2, 2);
    noisy(400, 2, 0);

    // R10 leaving and re-entering normal mode mid-bit
    tag = "R10";
    for (int r = 0; r < 6; r++) begin
      noisy(13 + r * 3, 2, 0);
      run = 1'b0;
      clocks(2 + r);
      run = 1'b1;
    end
    noisy(100, 3, 0);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule